// File: doc/BRIEF.md
# SDRAM Write Burst Engine with Early Termination

This block is the device-side write path of a synchronous DRAM with two banks and a 16-bit data bus. It receives already-decoded commands: a write command with a bank and a starting column, and a burst-terminate command. A write is followed by a run of data beats. The beat count comes from a configuration input: 1, 2, 4 or 8 beats, or a full-page run that keeps going until it is stopped. Each beat writes the data bus into a small storage array held inside the model. A per-byte mask input can block each byte of a beat from being stored.

The first beat is taken in the same clock as the write command. Each later beat uses the next column up, and the column wraps within the row. A terminate command ends the burst at once. The word on the bus in the terminate cycle is dropped, so the last stored word is the one from the clock before. A write that arrives during a burst starts a new burst at once. An idle output shows when no burst is running. A combinational look-up port lets the storage contents be inspected.

Top module: `sdram_wburst`

## Requirements
- R1: Reset clears the burst state: `idle` reads 1 and `wr_stb` reads 0 while reset is held and after it is released.
- R2: A write command stores its first beat in the same clock, at `cmd_bank`/`cmd_col`. The strobe, `wr_bank` and `wr_col` show that beat in that same cycle.
- R3: `burst_sel` selects the beat count: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives a full page. Codes 4, 5 and 6 act as a single beat.
- R4: Each beat after the first uses the previous column plus one, modulo the row size 2^COL_W. Each such beat writes the bank latched by the write command, and `cmd_bank`/`cmd_col` are ignored on those beats.
- R5: A full-page burst wraps around the row and keeps writing until it is terminated.
- R6: Bit i of `dqm` (1 = masked) stops byte i (bits 8i+7..8i) of that beat from being stored, and clears `wr_stb[i]`.
- R7: A terminate command during a burst stores nothing in its own cycle and ends the burst. This holds for both fixed-length and full-page bursts. The last stored word is the beat from the clock before the terminate.
- R8: A write command during a burst starts a new burst in that cycle, at the new bank and column and with the new length.
- R9: `idle` goes to 0 in the cycle after a write with a beat count above 1. It goes back to 1 in the cycle after the final beat or after a terminate.
- R10: A terminate command while idle changes neither the storage nor `idle`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_write | input | 1 | Decoded write command |
| cmd_term | input | 1 | Decoded burst-terminate command |
| cmd_bank | input | 1 | Bank select carried by a write |
| cmd_col | input | COL_W | Starting column carried by a write |
| burst_sel | input | 3 | Beat count code (see R3) |
| dq | input | 16 | Write data bus |
| dqm | input | 2 | Per-byte mask, 1 = do not store |
| wr_stb | output | 2 | Per-byte store strobes of the current beat |
| wr_bank | output | 1 | Bank of the current beat |
| wr_col | output | COL_W | Column of the current beat |
| idle | output | 1 | No burst running |
| peek_bank | input | 1 | Inspection bank |
| peek_col | input | COL_W | Inspection column |
| peek_data | output | 16 | Stored word at the inspection address |

## Verification
The bench builds the block with COL_W = 4, so each row has 16 columns. With rows this short, every fixed-length burst code can be started from columns across the whole row, in both banks. Full-page runs of 16 to 21 beats cross the row end, so column wrap is always exercised. After every burst the bench reads back all 32 words and checks them against a model that tracks each byte. It also runs every terminate position in an 8-beat burst, a restart in mid-burst, and a terminate while idle.

// File: rtl/sdram_wburst.sv
module sdram_wburst #(
  parameter int COL_W = 8,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_write,
  input  logic             cmd_term,
  input  logic             cmd_bank,
  input  logic [COL_W-1:0] cmd_col,
  input  logic [2:0]       burst_sel,
  input  logic [DW-1:0]    dq,
  input  logic [DW/8-1:0]  dqm,
  output logic [DW/8-1:0]  wr_stb,
  output logic             wr_bank,
  output logic [COL_W-1:0] wr_col,
  output logic             idle,
  input  logic             peek_bank,
  input  logic [COL_W-1:0] peek_col,
  output logic [DW-1:0]    peek_data
);
  localparam int NB    = DW / 8;
  localparam int WORDS = 2 << COL_W;

  logic [DW-1:0]    mem [WORDS];
  logic             active, full, bank, full_sel, beat;
  logic [COL_W-1:0] col;
  logic [2:0]       left, len_m1;

  always_comb begin
    case (burst_sel)
      3'd1:    len_m1 = 3'd1;
      3'd2:    len_m1 = 3'd3;
      3'd3:    len_m1 = 3'd7;
      default: len_m1 = 3'd0;
    endcase
  end

  assign full_sel = (burst_sel == 3'd7);
  assign beat     = cmd_write | (active & ~cmd_term);
  assign wr_col   = cmd_write ? cmd_col  : col;
  assign wr_bank  = cmd_write ? cmd_bank : bank;
  assign wr_stb   = beat ? ~dqm : '0;
  assign idle     = ~active;
  assign peek_data = mem[{peek_bank, peek_col}];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      full   <= 1'b0;
      bank   <= 1'b0;
      col    <= '0;
      left   <= '0;
    end else if (cmd_write) begin
      active <= full_sel || (len_m1 != 3'd0);
      full   <= full_sel;
      bank   <= cmd_bank;
      col    <= cmd_col + COL_W'(1);
      left   <= len_m1;
    end else if (active) begin
      if (cmd_term) begin
        active <= 1'b0;
      end else begin
        col  <= col + COL_W'(1);
        left <= left - 3'd1;
        if (!full && left == 3'd1) active <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NB; i++)
      if (wr_stb[i]) mem[{wr_bank, wr_col}][8*i +: 8] <= dq[8*i +: 8];
  end

  a_r4_col_step: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !cmd_write) |-> (wr_col == $past(wr_col) + COL_W'(1)));

  a_r4_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !cmd_write) |-> (wr_bank == $past(wr_bank)));

  a_r7_term_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_term && !cmd_write) |=> idle);

  a_r3_single_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_write && !(burst_sel inside {3'd1, 3'd2, 3'd3, 3'd7})) |=> idle);

  a_r9_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_write && (burst_sel inside {3'd1, 3'd2, 3'd3, 3'd7})) |=> !idle);
endmodule

// File: tb/sdram_wburst_bench.sv
`timescale 1ns/100ps
module sdram_wburst_bench;
  localparam int CW = 4, ROWS = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          cmd_write = 0, cmd_term = 0, cmd_bank = 0;
  logic [CW-1:0] cmd_col = '0;
  logic [2:0]    burst_sel = '0;
  logic [15:0]   dq = '0;
  logic [1:0]    dqm = '0;
  logic [1:0]    wr_stb;
  logic          wr_bank, idle;
  logic [CW-1:0] wr_col;
  logic          peek_bank = 0;
  logic [CW-1:0] peek_col = '0;
  logic [15:0]   peek_data;

  sdram_wburst #(.COL_W(CW), .DW(16)) u_sdram_wburst (
    .clk(clk), .rst_n(rst_n), .cmd_write(cmd_write), .cmd_term(cmd_term),
    .cmd_bank(cmd_bank), .cmd_col(cmd_col), .burst_sel(burst_sel), .dq(dq),
    .dqm(dqm), .wr_stb(wr_stb), .wr_bank(wr_bank), .wr_col(wr_col),
    .idle(idle), .peek_bank(peek_bank), .peek_col(peek_col), .peek_data(peek_data));

  int checks = 0, fails = 0, seq = 0;
  bit nomask = 0;
  logic [15:0] exp_mem [2][ROWS];

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(bit w, bit t, bit b, int c, logic [2:0] s,
                      bit eb, bit ebank, int ecol, string req);
    logic [15:0] d;
    logic [1:0]  m, es;
    @(negedge clk);
    seq++;
    d = 16'h5a3c ^ 16'(seq * 16'h0713);
    m = nomask ? 2'b00 : (seq % 5 == 3) ? 2'b01 : (seq % 7 == 4) ? 2'b10 : 2'b00;
    cmd_write = w; cmd_term = t; cmd_bank = b; cmd_col = CW'(c);
    burst_sel = s; dq = d; dqm = m;
    #1;
    es = eb ? ~m : 2'b00;
    chk(wr_stb === es, req, "wr_stb (R6 mask)", 32'(wr_stb), 32'(es));
    if (eb) begin
      chk(wr_col === CW'(ecol), req, "wr_col", 32'(wr_col), 32'(ecol % ROWS));
      chk(wr_bank === ebank, req, "wr_bank", 32'(wr_bank), 32'(ebank));
      for (int i = 0; i < 2; i++)
        if (!m[i]) exp_mem[ebank][ecol % ROWS][8*i +: 8] = d[8*i +: 8];
    end
  endtask

  task automatic chk_idle(bit e, string req);
    @(posedge clk);
    #1;
    chk(idle === e, req, "idle", 32'(idle), 32'(e));
  endtask

  task automatic chk_mem(string req);
    for (int b = 0; b < 2; b++)
      for (int c = 0; c < ROWS; c++) begin
        peek_bank = b[0];
        peek_col = CW'(c);
        #1;
        chk(peek_data === exp_mem[b][c], req, "stored word", 32'(peek_data), 32'(exp_mem[b][c]));
      end
  endtask

  task automatic run(bit b, int c, logic [2:0] s, int term, string req);
    int len, n;
    len = (s == 3'd1) ? 2 : (s == 3'd2) ? 4 : (s == 3'd3) ? 8 : (s == 3'd7) ? 1000 : 1;
    n = (term >= 1 && term < len) ? term : len;
    step(1, 0, b, c, s, 1, b, c, req);
    if (len > 1) chk_idle(0, "R9");
    for (int i = 1; i < n; i++)
      step(0, 0, ~b, c + 7, 3'd0, 1, b, (c + i) % ROWS, req);
    if (n < len) step(0, 1, ~b, c + 3, 3'd0, 0, b, 0, "R7");
    chk_idle(1, "R9");
    step(0, 0, 0, 0, 3'd0, 0, 0, 0, "R9");
    chk_mem(req);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(idle === 1'b1, "R1", "idle in reset", 32'(idle), 1);
    chk(wr_stb === 2'b00, "R1", "wr_stb in reset", 32'(wr_stb), 0);
    @(negedge clk);
    rst_n = 1'b1;
    chk_idle(1, "R1");

    nomask = 1;
    run(0, 0, 3'd7, 16, "R5");
    run(1, 5, 3'd7, 16, "R5");
    nomask = 0;

    for (int s = 0; s < 8; s++)
      for (int b = 0; b < 2; b++)
        for (int c = 0; c < ROWS; c += 3)
          run(b[0], c, 3'(s), (s == 7) ? 18 : -1, "R2 R3 R4");

    run(0, 9, 3'd7, 21, "R5");
    for (int t = 1; t < 8; t++) run(1, 13, 3'd3, t, "R7");
    run(0, 14, 3'd2, 3, "R7");

    step(1, 0, 0, 2, 3'd3, 1, 0, 2, "R8");
    step(0, 0, 1, 0, 3'd0, 1, 0, 3, "R8");
    step(0, 0, 1, 0, 3'd0, 1, 0, 4, "R8");
    step(1, 0, 1, 10, 3'd1, 1, 1, 10, "R8");
    step(0, 0, 0, 0, 3'd0, 1, 1, 11, "R8");
    chk_idle(1, "R8");
    step(0, 0, 0, 0, 3'd0, 0, 0, 0, "R8");
    chk_mem("R8");

    step(0, 1, 0, 3, 3'd0, 0, 0, 0, "R10");
    chk_idle(1, "R10");
    step(0, 0, 0, 0, 3'd0, 0, 0, 0, "R10");
    chk_idle(1, "R10");
    chk_mem("R10");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule